// File: doc/BRIEF.md
# Scaled Output Frame Start Calculator

This block finds the point inside an input video frame at which a scaled output frame should begin, so that the output raster starts after enough input lines have arrived for the scaler to work on. It takes the full timing of both rasters: sync length, back porch, active size and front porch in each axis, together with the pixel period of each side as an integer. From these it forms each side's back-porch delay as a time and adds a safety margin of whole input lines. It then folds the difference back into the input frame and reports the result as an input line index plus a pixel offset within that line.

A computation begins with a one-cycle start pulse. All timing inputs are captured on that edge. A single shift-and-add multiplier and a single restoring divider are shared by a small sequencer, and all intermediate values are 64 bits wide. When the result is ready, a one-cycle done pulse is raised. The outputs then hold until the next computation finishes.

Top module: `frame_start_calc`

## Requirements
- R1: Horizontal total is sync + back porch + active + front porch on each side, and the input vertical total uses the vertical fields the same way. Back-porch length in pixels is (vertical sync + vertical back porch) × horizontal total + horizontal sync + horizontal back porch.
- R2: Each back-porch length is multiplied by its own side's pixel period to form a time. The input frame time is input vertical total × input horizontal total × input pixel period. All products are 64-bit.
- R3: When the truncated ratio of input active lines to output active lines is 2 or less, the margin is 5 input line times (5 × input horizontal total × input pixel period).
- R4: When that ratio is greater than 2, the margin is 12 input line times.
- R5: When input back-porch time + margin is strictly greater than output back-porch time, the start time is the first minus the second.
- R6: Otherwise, including the case where the two are equal, the start time is the input frame time minus (output back-porch time − input back-porch time − margin).
- R7: The start time is divided by the input pixel period. That count divided by the input horizontal total gives start_line as the quotient and start_pix as the remainder. All divisions truncate.
- R8: busy is high from the edge after an accepted start until the result is ready. done is high for exactly one cycle when the result is ready. start_line and start_pix change only on that cycle.
- R9: A start pulse while busy is ignored. The timing inputs are captured when start is accepted, so later changes to them have no effect on the running computation.
- R10: After reset, busy and done are 0 and start_line and start_pix are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a computation |
| in_hsync | input | TW | Input horizontal sync length, pixels |
| in_hbp | input | TW | Input horizontal back porch, pixels |
| in_hact | input | TW | Input active width, pixels |
| in_hfp | input | TW | Input horizontal front porch, pixels |
| in_vsync | input | TW | Input vertical sync length, lines |
| in_vbp | input | TW | Input vertical back porch, lines |
| in_vact | input | TW | Input active height, lines |
| in_vfp | input | TW | Input vertical front porch, lines |
| out_hsync | input | TW | Output horizontal sync length, pixels |
| out_hbp | input | TW | Output horizontal back porch, pixels |
| out_hact | input | TW | Output active width, pixels |
| out_hfp | input | TW | Output horizontal front porch, pixels |
| out_vsync | input | TW | Output vertical sync length, lines |
| out_vbp | input | TW | Output vertical back porch, lines |
| out_vact | input | TW | Output active height, lines |
| out_vfp | input | TW | Output vertical front porch, lines |
| in_period | input | PW | Input pixel period, integer time units |
| out_period | input | PW | Output pixel period, integer time units |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| start_line | output | 64 | Input line index where the output frame starts |
| start_pix | output | 64 | Pixel offset within that input line |

## Verification
The hardest case to reach is the exact tie between input back-porch time plus margin and output back-porch time. In that case the wraparound branch must give a full input frame, so the result is a line index equal to the input vertical total and a pixel offset of zero. The stimulus reaches it with identical rasters and periods on both sides, and an output vertical back porch larger than the input one by exactly five lines. A second case aims at the ratio boundary: 59 input active lines against 20 output active lines truncates to a ratio of 2, so the short margin is expected, and a wrong rounding would show up as line 12 instead of line 5.

// File: rtl/fs_pkg.sv
package fs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_BPIN,
    ST_BPOUT,
    ST_TIN,
    ST_TOUT,
    ST_FPIX,
    ST_TFRM,
    ST_RATIO,
    ST_MPIX,
    ST_TMRG,
    ST_SUB,
    ST_CNT,
    ST_LINE
  } fs_state_e;

  localparam int unsigned MARGIN_SHORT = 5;
  localparam int unsigned MARGIN_LONG  = 12;
  localparam int unsigned RATIO_LIMIT  = 2;

endpackage

// File: rtl/fs_timing_sum.sv
module fs_timing_sum #(
  parameter int unsigned TW = 16
) (
  input  logic [TW-1:0] sync_len,
  input  logic [TW-1:0] porch_back,
  input  logic [TW-1:0] active_len,
  input  logic [TW-1:0] porch_front,
  output logic [TW+1:0] total,
  output logic [TW:0]   lead
);

  always_comb begin
    lead  = {1'b0, sync_len} + {1'b0, porch_back};
    total = {1'b0, lead} + {2'b00, active_len} + {2'b00, porch_front};
  end

endmodule

// File: rtl/fs_mul.sv
module fs_mul #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] prod
);

  logic [W-1:0] acc_q, acc_d;
  logic [W-1:0] mc_q, mc_d;
  logic [W-1:0] mp_q, mp_d;
  logic         busy_q, busy_d;
  logic         done_q, done_d;

  always_comb begin
    acc_d  = acc_q;
    mc_d   = mc_q;
    mp_d   = mp_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (!busy_q) begin
      if (go) begin
        acc_d  = '0;
        mc_d   = op_a;
        mp_d   = op_b;
        busy_d = 1'b1;
      end
    end else if (mp_q == '0) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end else begin
      if (mp_q[0]) acc_d = acc_q + mc_q;
      mc_d = mc_q << 1;
      mp_d = mp_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      mc_q   <= '0;
      mp_q   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      mc_q   <= mc_d;
      mp_q   <= mp_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign prod = acc_q;

  // R2: each multiply step consumes at least one multiplier bit
  mul_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (mp_q != '0)) |=> (mp_q < $past(mp_q)));

endmodule

// File: rtl/fs_div.sv
module fs_div #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);

  localparam int unsigned CW = $clog2(W) + 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  rem_q, rem_d;
  logic [W-1:0]  quo_q, quo_d;
  logic [W-1:0]  den_q, den_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [W:0]    trial;

  always_comb begin
    rem_d  = rem_q;
    quo_d  = quo_q;
    den_d  = den_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    trial  = {rem_q, quo_q[W-1]};
    if (!busy_q) begin
      if (go) begin
        rem_d  = '0;
        quo_d  = num;
        den_d  = den;
        cnt_d  = '0;
        busy_d = 1'b1;
      end
    end else begin
      if (trial >= {1'b0, den_q}) begin
        rem_d = W'(trial - {1'b0, den_q});
        quo_d = {quo_q[W-2:0], 1'b1};
      end else begin
        rem_d = trial[W-1:0];
        quo_d = {quo_q[W-2:0], 1'b0};
      end
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      den_q  <= den_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign quo  = quo_q;
  assign rem  = rem_q;

  // R7: the divider retires one quotient bit per busy cycle
  div_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> (!busy_q || (cnt_q == $past(cnt_q) + 1'b1)));

endmodule

// File: rtl/frame_start_calc.sv
module frame_start_calc
  import fs_pkg::*;
#(
  parameter int unsigned TW = 16,
  parameter int unsigned PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] in_hsync,
  input  logic [TW-1:0] in_hbp,
  input  logic [TW-1:0] in_hact,
  input  logic [TW-1:0] in_hfp,
  input  logic [TW-1:0] in_vsync,
  input  logic [TW-1:0] in_vbp,
  input  logic [TW-1:0] in_vact,
  input  logic [TW-1:0] in_vfp,
  input  logic [TW-1:0] out_hsync,
  input  logic [TW-1:0] out_hbp,
  input  logic [TW-1:0] out_hact,
  input  logic [TW-1:0] out_hfp,
  input  logic [TW-1:0] out_vsync,
  input  logic [TW-1:0] out_vbp,
  input  logic [TW-1:0] out_vact,
  input  logic [TW-1:0] out_vfp,
  input  logic [PW-1:0] in_period,
  input  logic [PW-1:0] out_period,
  output logic          busy,
  output logic          done,
  output logic [63:0]   start_line,
  output logic [63:0]   start_pix
);

  localparam int unsigned AW  = 64;
  localparam int unsigned NF  = 8;
  localparam int unsigned SW  = TW + 2;

  // reset: asserted asynchronously, released through two flops
  logic rst_s1, rst_s2, rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end
  assign rst_n_i = rst_s2;

  // captured timing: index 0..3 horizontal, 4..7 vertical
  logic [NF-1:0][TW-1:0] src_q, dst_q;
  logic [PW-1:0]         ipp_q, opp_q;
  logic                  cap_en;

  fs_state_e st_q, st_d;
  logic      go_q, go_d;
  logic      done_q, done_d;

  assign cap_en = (st_q == ST_IDLE) && start;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      src_q <= '0;
      dst_q <= '0;
      ipp_q <= '0;
      opp_q <= '0;
    end else if (cap_en) begin
      src_q <= {in_vfp, in_vact, in_vbp, in_vsync,
                in_hfp, in_hact, in_hbp, in_hsync};
      dst_q <= {out_vfp, out_vact, out_vbp, out_vsync,
                out_hfp, out_hact, out_hbp, out_hsync};
      ipp_q <= in_period;
      opp_q <= out_period;
    end
  end

  // R1: raster totals and leading (sync + back porch) lengths
  logic [SW-1:0] ih_tot, iv_tot, oh_tot;
  logic [TW:0]   ih_lead, iv_lead, oh_lead, ov_lead;

  fs_timing_sum #(.TW(TW)) u_in_h (
    .sync_len(src_q[0]), .porch_back(src_q[1]),
    .active_len(src_q[2]), .porch_front(src_q[3]),
    .total(ih_tot), .lead(ih_lead));

  fs_timing_sum #(.TW(TW)) u_in_v (
    .sync_len(src_q[4]), .porch_back(src_q[5]),
    .active_len(src_q[6]), .porch_front(src_q[7]),
    .total(iv_tot), .lead(iv_lead));

  fs_timing_sum #(.TW(TW)) u_out_h (
    .sync_len(dst_q[0]), .porch_back(dst_q[1]),
    .active_len(dst_q[2]), .porch_front(dst_q[3]),
    .total(oh_tot), .lead(oh_lead));

  assign ov_lead = {1'b0, dst_q[4]} + {1'b0, dst_q[5]};

  // intermediate results
  logic [AW-1:0] bp_in_q, bp_out_q, t_in_q, t_out_q;
  logic [AW-1:0] fpix_q, t_frm_q, ratio_q, mpix_q, t_mrg_q;
  logic [AW-1:0] t_st_q, cnt_q, line_q, pix_q;
  logic [AW-1:0] sum_in, t_st_d;
  logic [AW-1:0] margin_lines;

  // shared arithmetic units
  logic          mul_go, mul_busy, mul_done;
  logic          div_go, div_busy, div_done;
  logic [AW-1:0] mul_a, mul_b, mul_p;
  logic [AW-1:0] div_n, div_dn, div_q, div_r;
  logic          in_mul_st, in_div_st;

  always_comb begin
    in_mul_st = 1'b0;
    in_div_st = 1'b0;
    case (st_q)
      ST_BPIN, ST_BPOUT, ST_TIN, ST_TOUT,
      ST_FPIX, ST_TFRM, ST_MPIX, ST_TMRG: in_mul_st = 1'b1;
      ST_RATIO, ST_CNT, ST_LINE:          in_div_st = 1'b1;
      default: ;
    endcase
  end

  assign mul_go = go_q && in_mul_st;
  assign div_go = go_q && in_div_st;

  // R3 R4: margin length chosen from the truncated active-line ratio
  assign margin_lines = (ratio_q <= AW'(RATIO_LIMIT)) ? AW'(MARGIN_SHORT)
                                                      : AW'(MARGIN_LONG);

  always_comb begin
    mul_a = '0;
    mul_b = '0;
    case (st_q)
      ST_BPIN:  begin mul_a = AW'(iv_lead); mul_b = AW'(ih_tot); end
      ST_BPOUT: begin mul_a = AW'(ov_lead); mul_b = AW'(oh_tot); end
      ST_TIN:   begin mul_a = bp_in_q;      mul_b = AW'(ipp_q);  end
      ST_TOUT:  begin mul_a = bp_out_q;     mul_b = AW'(opp_q);  end
      ST_FPIX:  begin mul_a = AW'(iv_tot);  mul_b = AW'(ih_tot); end
      ST_TFRM:  begin mul_a = fpix_q;       mul_b = AW'(ipp_q);  end
      ST_MPIX:  begin mul_a = margin_lines; mul_b = AW'(ih_tot); end
      ST_TMRG:  begin mul_a = mpix_q;       mul_b = AW'(ipp_q);  end
      default: ;
    endcase
  end

  always_comb begin
    div_n  = '0;
    div_dn = '0;
    case (st_q)
      ST_RATIO: begin div_n = AW'(src_q[6]); div_dn = AW'(dst_q[6]); end
      ST_CNT:   begin div_n = t_st_q;        div_dn = AW'(ipp_q);    end
      ST_LINE:  begin div_n = cnt_q;         div_dn = AW'(ih_tot);   end
      default: ;
    endcase
  end

  fs_mul #(.W(AW)) u_mul (
    .clk(clk), .rst_n(rst_n_i), .go(mul_go), .op_a(mul_a), .op_b(mul_b),
    .busy(mul_busy), .done(mul_done), .prod(mul_p));

  fs_div #(.W(AW)) u_div (
    .clk(clk), .rst_n(rst_n_i), .go(div_go), .num(div_n), .den(div_dn),
    .busy(div_busy), .done(div_done), .quo(div_q), .rem(div_r));

  // R5 R6: direct difference or wrap through one input frame
  assign sum_in = t_in_q + t_mrg_q;
  assign t_st_d = (sum_in > t_out_q) ? (sum_in - t_out_q)
                                     : (t_frm_q - (t_out_q - sum_in));

  // sequencer: next state
  always_comb begin
    st_d   = st_q;
    go_d   = 1'b0;
    done_d = 1'b0;
    case (st_q)
      ST_IDLE:  if (start)    begin st_d = ST_BPIN;  go_d = 1'b1; end
      ST_BPIN:  if (mul_done) begin st_d = ST_BPOUT; go_d = 1'b1; end
      ST_BPOUT: if (mul_done) begin st_d = ST_TIN;   go_d = 1'b1; end
      ST_TIN:   if (mul_done) begin st_d = ST_TOUT;  go_d = 1'b1; end
      ST_TOUT:  if (mul_done) begin st_d = ST_FPIX;  go_d = 1'b1; end
      ST_FPIX:  if (mul_done) begin st_d = ST_TFRM;  go_d = 1'b1; end
      ST_TFRM:  if (mul_done) begin st_d = ST_RATIO; go_d = 1'b1; end
      ST_RATIO: if (div_done) begin st_d = ST_MPIX;  go_d = 1'b1; end
      ST_MPIX:  if (mul_done) begin st_d = ST_TMRG;  go_d = 1'b1; end
      ST_TMRG:  if (mul_done) st_d = ST_SUB;
      ST_SUB:   begin st_d = ST_CNT; go_d = 1'b1; end
      ST_CNT:   if (div_done) begin st_d = ST_LINE;  go_d = 1'b1; end
      ST_LINE:  if (div_done) begin st_d = ST_IDLE;  done_d = 1'b1; end
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q   <= ST_IDLE;
      go_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      go_q   <= go_d;
      done_q <= done_d;
    end
  end

  // result capture, one enable per stage
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      bp_in_q  <= '0;
      bp_out_q <= '0;
      t_in_q   <= '0;
      t_out_q  <= '0;
      fpix_q   <= '0;
      t_frm_q  <= '0;
      ratio_q  <= '0;
      mpix_q   <= '0;
      t_mrg_q  <= '0;
      t_st_q   <= '0;
      cnt_q    <= '0;
      line_q   <= '0;
      pix_q    <= '0;
    end else begin
      if (mul_done && st_q == ST_BPIN)  bp_in_q  <= mul_p + AW'(ih_lead);
      if (mul_done && st_q == ST_BPOUT) bp_out_q <= mul_p + AW'(oh_lead);
      if (mul_done && st_q == ST_TIN)   t_in_q   <= mul_p;
      if (mul_done && st_q == ST_TOUT)  t_out_q  <= mul_p;
      if (mul_done && st_q == ST_FPIX)  fpix_q   <= mul_p;
      if (mul_done && st_q == ST_TFRM)  t_frm_q  <= mul_p;
      if (div_done && st_q == ST_RATIO) ratio_q  <= div_q;
      if (mul_done && st_q == ST_MPIX)  mpix_q   <= mul_p;
      if (mul_done && st_q == ST_TMRG)  t_mrg_q  <= mul_p;
      if (st_q == ST_SUB)               t_st_q   <= t_st_d;
      if (div_done && st_q == ST_CNT)   cnt_q    <= div_q;
      if (div_done && st_q == ST_LINE) begin
        line_q <= div_q;
        pix_q  <= div_r;
      end
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign done       = done_q;
  assign start_line = line_q;
  assign start_pix  = pix_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    done_q |=> !done_q);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    !done_q |-> ($stable(line_q) && $stable(pix_q)));

  // R9
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (st_q != ST_IDLE) |=> ($stable(src_q) && $stable(dst_q) && $stable(ipp_q)));

  // R8
  unit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (st_q == ST_IDLE) |-> (!mul_busy && !div_busy));

endmodule

// File: tb/test_frame_start_calc.sv
module test_frame_start_calc;

  typedef struct {
    int hs, hbp, ha, hfp, vs, vbp, va, vfp;
  } tim_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] ihs, ihbp, iha, ihfp, ivs, ivbp, iva, ivfp;
  logic [15:0] ohs, ohbp, oha, ohfp, ovs, ovbp, ova, ovfp;
  logic [31:0] ipp, opp;
  logic        busy, done;
  logic [63:0] start_line, start_pix;

  int checks = 0;
  int errors = 0;
  longint cycles = 0;

  always #4 clk = ~clk;

  frame_start_calc i_frame_start_calc (
    .clk(clk), .rst_n(rst_n), .start(start),
    .in_hsync(ihs), .in_hbp(ihbp), .in_hact(iha), .in_hfp(ihfp),
    .in_vsync(ivs), .in_vbp(ivbp), .in_vact(iva), .in_vfp(ivfp),
    .out_hsync(ohs), .out_hbp(ohbp), .out_hact(oha), .out_hfp(ohfp),
    .out_vsync(ovs), .out_vbp(ovbp), .out_vact(ova), .out_vfp(ovfp),
    .in_period(ipp), .out_period(opp),
    .busy(busy), .done(done), .start_line(start_line), .start_pix(start_pix));

  task automatic summary_and_end();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      summary_and_end();
    end
  end

  task automatic check(string req, longint unsigned act, longint unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // independent reference from the requirement text
  function automatic void model(tim_t si, tim_t so, int pi, int po,
                                output longint unsigned ln,
                                output longint unsigned px);
    longint unsigned iht, ivt, oht, bpi, bpo, ti, to, tf, tm, s, st, c, rat, m;
    iht = si.hs + si.hbp + si.ha + si.hfp;
    ivt = si.vs + si.vbp + si.va + si.vfp;
    oht = so.hs + so.hbp + so.ha + so.hfp;
    bpi = (si.vbp + si.vs) * iht + si.hs + si.hbp;
    bpo = (so.vbp + so.vs) * oht + so.hs + so.hbp;
    ti = bpi * pi;
    to = bpo * po;
    tf = ivt * iht * pi;
    rat = longint'(si.va) / longint'(so.va);
    m = (rat <= 2) ? 5 : 12;
    tm = m * iht * pi;
    s = ti + tm;
    st = (s > to) ? (s - to) : (tf - (to - s));
    c = st / pi;
    ln = c / iht;
    px = c % iht;
  endfunction

  task automatic drive(tim_t si, tim_t so, int pi, int po);
    ihs = 16'(si.hs); ihbp = 16'(si.hbp); iha = 16'(si.ha); ihfp = 16'(si.hfp);
    ivs = 16'(si.vs); ivbp = 16'(si.vbp); iva = 16'(si.va); ivfp = 16'(si.vfp);
    ohs = 16'(so.hs); ohbp = 16'(so.hbp); oha = 16'(so.ha); ohfp = 16'(so.hfp);
    ovs = 16'(so.vs); ovbp = 16'(so.vbp); ova = 16'(so.va); ovfp = 16'(so.vfp);
    ipp = 32'(pi); opp = 32'(po);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(string req);
    int n = 0;
    while (!done && n < 6000) begin
      @(negedge clk);
      n++;
    end
    checks++;
    if (!done) begin
      errors++;
      $display("FAIL %s: actual no done expected done pulse", req);
    end
  endtask

  task automatic run(string req, tim_t si, tim_t so, int pi, int po,
                     longint unsigned eln, longint unsigned epx);
    longint unsigned l0, p0;
    @(negedge clk);
    drive(si, so, pi, po);
    pulse_start();
    check({req, " R8 busy"}, longint'(busy), 1);
    wait_done(req);
    check({req, " line R7"}, start_line, eln);
    check({req, " pix R7"}, start_pix, epx);
    l0 = start_line;
    p0 = start_pix;
    @(negedge clk);
    check("R8 done width", longint'(done), 0);
    check("R8 busy clear", longint'(busy), 0);
    repeat (5) @(negedge clk);
    check("R8 line hold", start_line, l0);
    check("R8 pix hold", start_pix, p0);
  endtask

  tim_t base_t  = '{8, 10, 40, 6, 2, 3, 20, 4};

  task automatic t_reset();
    check("R10 busy", longint'(busy), 0);
    check("R10 done", longint'(done), 0);
    check("R10 line", start_line, 0);
    check("R10 pix", start_pix, 0);
  endtask

  // R3 R5: identical rasters, margin of 5 lines gives line 5
  task automatic t_identity();
    run("R3 R5 identity", base_t, base_t, 10, 10, 5, 0);
  endtask

  // R1 R2 R4 R5: 3:1 vertical downscale, long margin
  task automatic t_down3();
    tim_t si = '{8, 10, 40, 6, 2, 3, 60, 4};
    tim_t so = '{4, 6, 20, 2, 1, 2, 20, 1};
    longint unsigned l, p;
    model(si, so, 10, 30, l, p);
    run("R1 R2 R4 down3", si, so, 10, 30, l, p);
  endtask

  // R3: 59/20 truncates to 2, short margin -> line 5 (long margin would be 12)
  task automatic t_ratio_edge();
    tim_t si = '{8, 10, 40, 6, 2, 3, 59, 4};
    tim_t so = '{8, 10, 40, 6, 2, 3, 20, 4};
    run("R3 ratio edge", si, so, 10, 10, 5, 0);
  endtask

  // R6: output back porch much longer, wraps through the input frame
  task automatic t_wrap();
    tim_t so = '{8, 10, 40, 6, 2, 20, 20, 4};
    longint unsigned l, p;
    model(base_t, so, 10, 10, l, p);
    run("R6 wrap", base_t, so, 10, 10, l, p);
    check("R6 wrap line value", l, 17);
  endtask

  // R6: exact tie -> full frame, line = input vertical total (29)
  task automatic t_tie();
    tim_t so = '{8, 10, 40, 6, 2, 8, 20, 4};
    run("R6 tie", base_t, so, 10, 10, 29, 0);
  endtask

  // R2 R7: different output period, non-zero pixel remainder
  task automatic t_remainder();
    tim_t so = '{8, 10, 40, 6, 2, 3, 20, 4};
    longint unsigned l, p;
    model(base_t, so, 10, 7, l, p);
    run("R2 R7 remainder", base_t, so, 10, 7, l, p);
  endtask

  // R9: second start while busy, with new inputs, is ignored
  task automatic t_ignore();
    tim_t so = '{8, 10, 40, 6, 2, 20, 20, 4};
    @(negedge clk);
    drive(base_t, base_t, 10, 10);
    pulse_start();
    repeat (20) @(negedge clk);
    drive(base_t, so, 13, 3);
    check("R9 busy at second start", longint'(busy), 1);
    pulse_start();
    wait_done("R9");
    check("R9 line keeps first request", start_line, 5);
    check("R9 pix keeps first request", start_pix, 0);
    @(negedge clk);
    check("R9 no second run", longint'(busy), 0);
    repeat (30) @(negedge clk);
    check("R9 no late done", longint'(done), 0);
    check("R9 line unchanged", start_line, 5);
  endtask

  initial begin
    drive(base_t, base_t, 10, 10);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_identity();
    t_down3();
    t_ratio_edge();
    t_wrap();
    t_tie();
    t_remainder();
    t_ignore();
    summary_and_end();
  end

endmodule